// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous memory whose words are split into byte lanes. With the default parameters a word has four lanes of nine bits, so it is 36 bits wide. Every input is captured by a register on the rising clock edge before it acts: the address, the write data, the three chip selects and the write controls. A write is then committed on the following edge with no handshake. A read loads a registered output stage. The pad-drive enable for the data output is the pipelined read flag gated by an asynchronous output-enable input.

Three chip selects allow several of these blocks to share one data bus. When a block is deselected, its output drive stops one cycle after that command is registered. This lets a neighbour take the bus without contention. Lane writes are masked by per-lane enables, and those enables act only while the byte-write enable is low. A global write overrides the mask and writes every lane.

There is no valid/ready handshake. Each cycle carries at most one command: a read, a write or no operation. Every command is accepted, so back-pressure is never applied. The data output is given as a value `q` and a drive flag `q_en`. The tristate pad is built from the two at the chip boundary.

Top module: `pbw_sram`

## Requirements
- R1: A command takes effect only when `cs_n` is low, `cs_hi` is high and `cs2_n` is low. Any other combination writes no lane and gives no output drive.
- R2: While `gw_n` is high and `bwe_n` is low, lane i (bits [9i+8:9i]) is written exactly when `bw_n[i]` is low. The other lanes keep their contents.
- R3: While both `gw_n` and `bwe_n` are high, the `bw_n` inputs have no effect and no lane is written. The command is then a read.
- R4: While `gw_n` is low, all lanes are written whatever `bwe_n` and `bw_n` are.
- R5: For a read presented before rising edge k, `q` holds the addressed word and `q_en` is high after edge k+1, as long as `oe_n` is low.
- R6: A read presented in the cycle right after a write to the same address returns the newly written lanes merged with the unwritten ones.
- R7: After a deselect command is registered, the drive set up by a previous read stays on for one more cycle. `q_en` falls after the edge that follows.
- R8: `oe_n` high forces `q_en` low at once, with no clock edge needed. Returning `oe_n` low restores the pipelined drive.
- R9: While reset is asserted and after it is released, `q_en` stays low until a read has passed through the pipeline.
- R10: A write command gives no output drive in the cycle in which its data would have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Second chip select, active low |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies `bw_n` |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| d | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| q | output | LANES*LANE_W | Registered read data |
| q_en | output | 1 | High when the data pad should be driven |

## Verification
The bench runs full-word writes made with the global write and partial writes whose lane masks are 1110, 0101 and 0000. Reading those words back shows that each lane follows its own enable bit and that no two lanes are swapped. The bench also issues writes with the byte-write enable high, with and without the global write. These separate the override path from the qualified mask path. It applies each of the three single-pin deselect patterns together with a global write, which shows that a single inactive select blocks the command. Read-after-write at one address, back-to-back reads of different addresses, and a read followed by a deselect separate the read latency from the pass-through and from the one-cycle delayed release of the bus.

// File: rtl/pbw_sram_pkg.sv
package pbw_sram_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  function automatic logic [3:0] lane_mask4(input logic gw_n_i,
                                            input logic bwe_n_i,
                                            input logic [3:0] bw_n_i);
    if (!gw_n_i)       return 4'hF;
    else if (!bwe_n_i) return ~bw_n_i;
    else               return 4'h0;
  endfunction

endpackage

// File: rtl/pbw_cmd_stage.sv
module pbw_cmd_stage
  import pbw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     cs_hi,
  input  logic                     cs2_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [LANES-1:0]         bw_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  d,
  output acc_kind_t                acc,
  output logic [LANES-1:0]         lane_we,
  output logic [ADDR_W-1:0]        addr_q,
  output logic [LANES*LANE_W-1:0]  d_q
);

  logic             cs_n_q, cs_hi_q, cs2_n_q;
  logic             gw_n_q, bwe_n_q;
  logic [LANES-1:0] bw_n_q;
  logic             sel_q;

  // control registers: reset to a deselected, non-writing state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q  <= 1'b1;
      cs_hi_q <= 1'b0;
      cs2_n_q <= 1'b1;
      gw_n_q  <= 1'b1;
      bwe_n_q <= 1'b1;
      bw_n_q  <= '1;
    end else begin
      cs_n_q  <= cs_n;
      cs_hi_q <= cs_hi;
      cs2_n_q <= cs2_n;
      gw_n_q  <= gw_n;
      bwe_n_q <= bwe_n;
      bw_n_q  <= bw_n;
    end
  end

  // address and data need no reset
  always_ff @(posedge clk) begin
    addr_q <= addr;
    d_q    <= d;
  end

  assign sel_q = !cs_n_q && cs_hi_q && !cs2_n_q;

  // lane mask: global write overrides, byte enables qualified by bwe_n
  always_comb begin
    lane_we = '0;
    if (sel_q) begin
      if (!gw_n_q)       lane_we = '1;
      else if (!bwe_n_q) lane_we = ~bw_n_q;
    end
  end

  always_comb begin
    if (!sel_q)          acc = ACC_IDLE;
    else if (|lane_we)   acc = ACC_WRITE;
    else                 acc = ACC_READ;
  end

  logic sel_in;
  assign sel_in = !cs_n && cs_hi && !cs2_n;

  a_r1_deselect_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |=> (lane_we == '0 && acc == ACC_IDLE));

  a_r2_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && gw_n && !bwe_n) |=> (lane_we == ~$past(bw_n)));

  a_r3_bw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && gw_n && bwe_n) |=> (lane_we == '0 && acc == ACC_READ));

  a_r4_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && !gw_n) |=> (lane_we == '1));

endmodule

// File: rtl/pbw_lane_array.sv
module pbw_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // write commits on the edge after registration; a read registered on
  // that same edge is looked up on the next one, so it sees the new value
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/pbw_out_stage.sv
module pbw_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic oe_n,
  output logic q_en
);

  logic drive_q;

  // pipelined select: deselect releases the bus one cycle later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= rd_en;
  end

  // output enable acts without a clock
  assign q_en = drive_q && !oe_n;

endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
  import pbw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     cs_hi,
  input  logic                     cs2_n,
  input  logic                     gw_n,
  input  logic                     bwe_n,
  input  logic [LANES-1:0]         bw_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  d,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  q,
  output logic                     q_en
);

  localparam int WORD_W = LANES * LANE_W;

  acc_kind_t         acc;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] d_q;
  logic              rd_en;

  pbw_cmd_stage #(
    .ADDR_W(ADDR_W),
    .LANES (LANES),
    .LANE_W(LANE_W)
  ) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .cs_hi  (cs_hi),
    .cs2_n  (cs2_n),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .addr   (addr),
    .d      (d),
    .acc    (acc),
    .lane_we(lane_we),
    .addr_q (addr_q),
    .d_q    (d_q)
  );

  assign rd_en = (acc == ACC_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbw_lane_array #(
      .ADDR_W(ADDR_W),
      .LANE_W(LANE_W)
    ) u_lane (
      .clk  (clk),
      .we   (lane_we[g]),
      .re   (rd_en),
      .addr (addr_q),
      .wdata(d_q[g*LANE_W +: LANE_W]),
      .rdata(q[g*LANE_W +: LANE_W])
    );
  end

  pbw_out_stage u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_en(rd_en),
    .oe_n (oe_n),
    .q_en (q_en)
  );

  logic sel_in, wr_in;
  assign sel_in = !cs_n && cs_hi && !cs2_n;
  assign wr_in  = !gw_n || (!bwe_n && (bw_n != '1));

  a_r10_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_in && wr_in) |=> ##1 !q_en);

  a_r7_deselect_release: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in |=> ##1 !q_en);

endmodule

// File: tb/tb_pbw_sram.sv
module tb_pbw_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, cs_hi = 1'b0, cs2_n = 1'b1;
  logic          gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] d = '0;
  logic          oe_n = 1'b0;
  logic [WW-1:0] q;
  logic          q_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [WW-1:0] model [256];

  int          due_q[$];
  bit          en_q[$];
  logic [WW-1:0] dat_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pbw_sram dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs2_n(cs2_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .addr(addr), .d(d),
    .oe_n(oe_n), .q(q), .q_en(q_en)
  );

  // driver: one command per cycle, expected result pushed to the scoreboard
  task automatic issue(input logic c_n, input logic c_hi, input logic c2_n,
                       input logic g_n, input logic be_n, input logic [3:0] b_n,
                       input logic [AW-1:0] a, input logic [WW-1:0] wd,
                       input string req);
    logic       sel;
    logic [3:0] lanes;
    @(negedge clk);
    cs_n = c_n; cs_hi = c_hi; cs2_n = c2_n;
    gw_n = g_n; bwe_n = be_n; bw_n = b_n; addr = a; d = wd;
    sel   = !c_n && c_hi && !c2_n;
    lanes = !g_n ? 4'hF : (!be_n ? ~b_n : 4'h0);
    if (sel) begin
      for (int i = 0; i < 4; i++)
        if (lanes[i]) model[a][i*9 +: 9] = wd[i*9 +: 9];
    end
    due_q.push_back(cyc + 2);
    en_q.push_back(sel && lanes == 4'h0);
    dat_q.push_back(model[a]);
    req_q.push_back(req);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [WW-1:0] wd, input string req);
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, a, wd, req);
  endtask

  task automatic bwr(input logic [3:0] b_n, input logic [AW-1:0] a,
                     input logic [WW-1:0] wd, input string req);
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, b_n, a, wd, req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, a, '0, req);
  endtask

  task automatic idle(input string req);
    issue(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, '0, '0, req);
  endtask

  task automatic check_en(input bit exp, input string req);
    checks++;
    if (q_en !== exp) begin
      errors++;
      $display("FAIL %s: q_en actual=%b expected=%b", req, q_en, exp);
    end
  endtask

  // monitor: pops each item in the cycle its result is due
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      int          du;
      bit          e;
      logic [WW-1:0] x;
      string       r;
      du = due_q.pop_front();
      e  = en_q.pop_front();
      x  = dat_q.pop_front();
      r  = req_q.pop_front();
      checks++;
      if (q_en !== e || (e && q !== x)) begin
        errors++;
        $display("FAIL %s: q_en=%b q=%h actual, q_en=%b q=%h expected (due %0d)",
                 r, q_en, q, e, x, du);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R5: watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_en(1'b0, "R9 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_en(1'b0, "R9 after reset");

    // R4 / R6 / R10: full write, then immediate read of the same word
    wr(8'h10, 36'hA_BCDE_F012, "R10 write no drive");
    rd(8'h10, "R6 pass-through");
    // R5: back-to-back reads of differing words
    wr(8'h11, 36'h1_2345_6789, "R10 write");
    wr(8'h12, 36'hF_0F0F_0F0F, "R10 write");
    rd(8'h11, "R5 read latency");
    rd(8'h12, "R5 read latency");
    rd(8'h10, "R5 read latency");

    // R2: partial lane writes under bwe_n
    bwr(4'b1110, 8'h11, 36'hF_FFFF_FFFF, "R2 lane0 only");
    rd(8'h11, "R2 lane0 only / R6");
    bwr(4'b0101, 8'h12, 36'h0_0000_0000, "R2 lanes1,3");
    rd(8'h12, "R2 lanes1,3");
    bwr(4'b0000, 8'h13, 36'h5_5555_5555, "R2 all lanes");
    rd(8'h13, "R2 all lanes");

    // R3: bw_n ignored without bwe_n
    issue(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b0000, 8'h10, 36'h0, "R3 bw ignored");
    rd(8'h10, "R3 contents kept");
    // R4: global write overrides bwe_n high and bw_n all high
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1111, 8'h14, 36'h9_8765_4321, "R4 global");
    rd(8'h14, "R4 all lanes");
    issue(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 8'h14, 36'h3_3333_3333, "R4 global over mask");
    rd(8'h14, "R4 all lanes over mask");

    // R1: each single inactive select blocks a global write
    issue(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'hF, 8'h13, 36'h0, "R1 cs_n high");
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 8'h13, 36'h0, "R1 cs_hi low");
    issue(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 8'h13, 36'h0, "R1 cs2_n high");
    rd(8'h13, "R1 word unchanged");

    // R7: read then deselect; drive lasts one cycle, then releases
    rd(8'h12, "R7 read before deselect");
    idle("R7 released after deselect");
    idle("R7 stays released");

    // R8: asynchronous output enable during a held read
    rd(8'h11, "R8 setup read");
    repeat (3) @(negedge clk);
    #2;
    oe_n = 1'b1;
    #1;
    check_en(1'b0, "R8 oe_n high");
    oe_n = 1'b0;
    #1;
    check_en(1'b1, "R8 oe_n low again");
    checks++;
    if (q !== model[8'h11]) begin
      errors++;
      $display("FAIL R8: q actual=%h expected=%h", q, model[8'h11]);
    end
    idle("R7 release after held read");
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule